// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shift Register

This block turns an eight-bit word into a serial bit stream. A word presented on the parallel inputs is captured into an eight-stage chain while the active-low load pin is held low. Once the load pin is released, every effective clock edge moves the chain one stage from the first stage toward the last. The serial input fills the first stage and the last stage drives a true and an inverted output.

The slow external pins are sampled by a fast system clock. The clock and inhibit pins are combined as a NOR gate would combine them: either pin held high blocks shifting, and either pin held low lets the other act as the clock. The block shifts when the OR of the two synchronized pins rises. A small state machine tracks the combined level in three states. ST_GATED means the combined level is high. ST_OPEN means it is low and the chain is armed. ST_LOAD means the load pin is low. Its transitions are: any state goes to ST_LOAD while load is low. ST_LOAD leaves to ST_GATED or ST_OPEN according to the combined level. ST_GATED goes to ST_OPEN when the level falls. ST_OPEN goes to ST_GATED when the level rises, and that transition is the one that emits a shift. Reset enters ST_GATED.

Top module: `piso_gated_shifter`

## Requirements
- R1: A synchronous active-high reset clears all stages, so `q_o` reads 0 and `q_n_o` reads 1.
- R2: While `ld_n_i` is low, stage k takes `par_i[k]` every cycle. Bit 0 is the first stage and bit 7 is the last, so `q_o` shows `par_i[7]`.
- R3: While `ld_n_i` is low, edges on `ext_clk_i` or `inh_i` have no effect on the chain.
- R4: With `ld_n_i` high, each shift moves stage k into stage k+1. After a load and eight shifts with `ser_i` at 0, `q_o` presents `par_i[7]` down to `par_i[0]` and then reads 0.
- R5: On each shift, the first stage takes `ser_i`.
- R6: While `inh_i` is high, toggling `ext_clk_i` does not shift the chain.
- R7: A rising edge on either pin while the other is low is a shift. This includes a rise of `inh_i` while `ext_clk_i` is low.
- R8: With `ld_n_i` high and no rise of the combined level, every stage holds its value.
- R9: `q_n_o` is always the inverse of `q_o`.
- R10: A pin change is reflected at the outputs on the third system-clock edge after it, because of two synchronizer flops and one chain flop.
- R11: Releasing `ld_n_i` while the combined level is high does not cause a shift. The next shift needs the level to fall and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock that samples all pins |
| sys_rst | input | 1 | Synchronous active-high reset |
| ld_n_i | input | 1 | Active-low parallel load, level-sensitive |
| par_i | input | 8 | Parallel word, bit k for stage k |
| ser_i | input | 1 | Serial data into the first stage |
| ext_clk_i | input | 1 | External shift clock |
| inh_i | input | 1 | Clock inhibit, combined with the clock |
| q_o | output | 1 | Last stage, true |
| q_n_o | output | 1 | Last stage, inverted |

## Verification
The bench aims at the four places where a gated clock and a level load interact. Clock pulses during a load must not shift; a design without load priority would lose the top bit. Releasing the load with the clock high must not shift; a naive edge detector would see a phantom edge and skip bit 7. A rise of the inhibit pin with the clock low must shift; a design that ignored inhibit as a clock source would keep the old bit. Clock pulses under a high inhibit must not shift. The bench also samples the edge where the output first changes, so an extra or missing synchronizer flop shows up as a one-cycle shift in the bit sequence.

// File: rtl/piso_pkg.sv
package piso_pkg;
    typedef enum logic [1:0] {
        ST_GATED = 2'd0,
        ST_OPEN  = 2'd1,
        ST_LOAD  = 2'd2
    } gate_st_e;

    localparam int unsigned PIN_CLK = 0;
    localparam int unsigned PIN_INH = 1;
    localparam int unsigned PIN_LDN = 2;
    localparam int unsigned PIN_CNT = 3;
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int unsigned       WIDTH   = 3,
    parameter int unsigned       DEPTH   = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_flop
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[DEPTH-1];
endmodule

// File: rtl/piso_gate_fsm.sv
module piso_gate_fsm
    import piso_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clk_s_i,
    input  logic     inh_s_i,
    input  logic     ld_n_s_i,
    output logic     load_o,
    output logic     shift_o,
    output gate_st_e state_o
);
    gate_st_e st, st_nxt;
    logic     lvl_hi;
    logic     ld_lo;

    assign lvl_hi = clk_s_i | inh_s_i;
    assign ld_lo  = ~ld_n_s_i;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_GATED;
        else     st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_LOAD: begin
                if (ld_lo)       st_nxt = ST_LOAD;
                else if (lvl_hi) st_nxt = ST_GATED;
                else             st_nxt = ST_OPEN;
            end
            ST_GATED: begin
                if (ld_lo)        st_nxt = ST_LOAD;
                else if (!lvl_hi) st_nxt = ST_OPEN;
                else              st_nxt = ST_GATED;
            end
            ST_OPEN: begin
                if (ld_lo)       st_nxt = ST_LOAD;
                else if (lvl_hi) st_nxt = ST_GATED;
                else             st_nxt = ST_OPEN;
            end
            default: st_nxt = ST_GATED;
        endcase
    end

    always_comb begin
        load_o  = ld_lo;
        shift_o = 1'b0;
        unique case (st)
            ST_OPEN:  shift_o = lvl_hi & ~ld_lo;
            ST_GATED: shift_o = 1'b0;
            ST_LOAD:  shift_o = 1'b0;
            default:  shift_o = 1'b0;
        endcase
    end

    assign state_o = st;
endmodule

// File: rtl/piso_stage_chain.sv
module piso_stage_chain #(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [STAGES-1:0] par_i,
    input  logic              ser_i,
    output logic [STAGES-1:0] stg_o
);
    logic [STAGES-1:0] stg;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            logic from_prev;
            if (k == 0) begin : g_head
                assign from_prev = ser_i;
            end else begin : g_body
                assign from_prev = stg[k-1];
            end
            always_ff @(posedge clk) begin
                if (rst)          stg[k] <= 1'b0;
                else if (load_i)  stg[k] <= par_i[k];
                else if (shift_i) stg[k] <= from_prev;
            end
        end
    endgenerate

    assign stg_o = stg;
endmodule

// File: rtl/piso_gated_shifter.sv
module piso_gated_shifter
    import piso_pkg::*;
#(
    parameter int unsigned STAGES     = 8,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic              sys_clk,
    input  logic              sys_rst,
    input  logic              ld_n_i,
    input  logic [STAGES-1:0] par_i,
    input  logic              ser_i,
    input  logic              ext_clk_i,
    input  logic              inh_i,
    output logic              q_o,
    output logic              q_n_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [PIN_CNT-1:0] pins_raw, pins_s;
    logic               load_en, shift_pls;
    gate_st_e           gate_st;
    logic [STAGES-1:0]  stg;

    always_comb begin
        pins_raw          = '0;
        pins_raw[PIN_CLK] = ext_clk_i;
        pins_raw[PIN_INH] = inh_i;
        pins_raw[PIN_LDN] = ld_n_i;
    end

    piso_sync #(
        .WIDTH  (PIN_CNT),
        .DEPTH  (SYNC_DEPTH),
        .RST_VAL({PIN_CNT{1'b1}})
    ) u_sync (
        .clk(sys_clk),
        .rst(sys_rst),
        .d_i(pins_raw),
        .q_o(pins_s)
    );

    piso_gate_fsm u_fsm (
        .clk     (sys_clk),
        .rst     (sys_rst),
        .clk_s_i (pins_s[PIN_CLK]),
        .inh_s_i (pins_s[PIN_INH]),
        .ld_n_s_i(pins_s[PIN_LDN]),
        .load_o  (load_en),
        .shift_o (shift_pls),
        .state_o (gate_st)
    );

    piso_stage_chain #(.STAGES(STAGES)) u_chain (
        .clk    (sys_clk),
        .rst    (sys_rst),
        .load_i (load_en),
        .shift_i(shift_pls),
        .par_i  (par_i),
        .ser_i  (ser_i),
        .stg_o  (stg)
    );

    assign q_o   = stg[LAST];
    assign q_n_o = ~stg[LAST];
endmodule

// File: rtl/piso_gated_shifter_chk.sv
module piso_gated_shifter_chk
    import piso_pkg::*;
#(
    parameter int unsigned STAGES = 8
) (
    input logic              sys_clk,
    input logic              sys_rst,
    input logic [STAGES-1:0] par_i,
    input logic              ser_i,
    input logic              q_o,
    input logic              q_n_o,
    input logic              load_en,
    input logic              shift_pls,
    input gate_st_e          gate_st,
    input logic [STAGES-1:0] stg
);
    assert_reset_clear_R1: assert property (@(posedge sys_clk)
        sys_rst |=> (stg == '0 && q_o == 1'b0));

    assert_load_capture_R2: assert property (@(posedge sys_clk) disable iff (sys_rst)
        load_en |=> (stg == $past(par_i)));

    assert_load_blocks_shift_R3: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (gate_st == ST_LOAD) |-> !shift_pls);

    assert_shift_move_R4: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (shift_pls && !load_en) |=> (stg[STAGES-1:1] == $past(stg[STAGES-2:0])));

    assert_serial_entry_R5: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (shift_pls && !load_en) |=> (stg[0] == $past(ser_i)));

    assert_hold_R8: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (!shift_pls && !load_en) |=> $stable(stg));

    assert_complement_R9: assert property (@(posedge sys_clk) disable iff (sys_rst)
        q_n_o == ~q_o);

    assert_release_no_shift_R11: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (gate_st == ST_GATED) |-> !shift_pls);
endmodule

bind piso_gated_shifter piso_gated_shifter_chk #(.STAGES(STAGES)) u_chk (
    .sys_clk  (sys_clk),
    .sys_rst  (sys_rst),
    .par_i    (par_i),
    .ser_i    (ser_i),
    .q_o      (q_o),
    .q_n_o    (q_n_o),
    .load_en  (load_en),
    .shift_pls(shift_pls),
    .gate_st  (gate_st),
    .stg      (stg)
);

// File: tb/piso_gated_shifter_bench.sv
module piso_gated_shifter_bench;
    localparam int unsigned W      = 8;
    localparam int unsigned SETTLE = 5;

    logic         sys_clk = 1'b0;
    logic         sys_rst = 1'b1;
    logic         ld_n_i  = 1'b1;
    logic [W-1:0] par_i   = '0;
    logic         ser_i   = 1'b0;
    logic         ext_clk_i = 1'b0;
    logic         inh_i   = 1'b0;
    logic         q_o, q_n_o;

    typedef struct {
        logic  exp;
        string tag;
    } sb_item_t;

    sb_item_t     sb_q[$];
    event         samp;
    int           n_chk  = 0;
    int           n_fail = 0;
    logic [W-1:0] model  = '0;

    always #10 sys_clk = ~sys_clk;

    piso_gated_shifter u_piso_gated_shifter (
        .sys_clk  (sys_clk),
        .sys_rst  (sys_rst),
        .ld_n_i   (ld_n_i),
        .par_i    (par_i),
        .ser_i    (ser_i),
        .ext_clk_i(ext_clk_i),
        .inh_i    (inh_i),
        .q_o      (q_o),
        .q_n_o    (q_n_o)
    );

    task automatic drain();
        while (sb_q.size() > 0) begin
            sb_item_t it = sb_q.pop_front();
            n_chk++;
            if (q_o !== it.exp || q_n_o !== ~it.exp) begin
                n_fail++;
                $display("FAIL %s: q=%b qn=%b expected q=%b qn=%b",
                         it.tag, q_o, q_n_o, it.exp, ~it.exp);
            end
        end
    endtask

    initial begin
        forever begin
            @(samp);
            drain();
        end
    end

    task automatic expect_q(input string tag, input logic e);
        sb_item_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        -> samp;
        #1;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic set_clk(input logic v);
        @(negedge sys_clk);
        ext_clk_i = v;
        wait_n(SETTLE);
    endtask

    task automatic set_inh(input logic v);
        @(negedge sys_clk);
        inh_i = v;
        wait_n(SETTLE);
    endtask

    task automatic model_shift();
        model = {model[W-2:0], ser_i};
    endtask

    task automatic load_word(input logic [W-1:0] w);
        @(negedge sys_clk);
        par_i  = w;
        ld_n_i = 1'b0;
        wait_n(SETTLE);
        model = w;
        expect_q("R2 load shows last stage", model[W-1]);
        @(negedge sys_clk);
        ld_n_i = 1'b1;
        wait_n(SETTLE);
    endtask

    task automatic clk_pulse_shift(input string tag);
        set_clk(1'b1);
        model_shift();
        expect_q(tag, model[W-1]);
        set_clk(1'b0);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_n(4);
        expect_q("R1 reset clears output", 1'b0);
        @(negedge sys_clk);
        sys_rst = 1'b0;
        wait_n(SETTLE);
        expect_q("R1 after reset release", 1'b0);

        wait_n(10);
        expect_q("R8 idle hold", 1'b0);

        // R2 and R3: load, then clock pulses during load are ignored
        @(negedge sys_clk);
        par_i  = 8'hB4;
        ld_n_i = 1'b0;
        wait_n(SETTLE);
        model = 8'hB4;
        expect_q("R2 load of B4", model[W-1]);
        ext_clk_i = 1'b1; wait_n(SETTLE);
        ext_clk_i = 1'b0; wait_n(SETTLE);
        ext_clk_i = 1'b1; wait_n(SETTLE);
        ext_clk_i = 1'b0; wait_n(SETTLE);
        expect_q("R3 clock during load ignored", model[W-1]);
        ld_n_i = 1'b1;
        wait_n(SETTLE);
        expect_q("R3 after release", model[W-1]);

        // R10: latency of exactly three system edges
        @(negedge sys_clk);
        ext_clk_i = 1'b1;
        @(negedge sys_clk);
        expect_q("R10 unchanged after 1 edge", model[W-1]);
        @(negedge sys_clk);
        expect_q("R10 unchanged after 2 edges", model[W-1]);
        @(negedge sys_clk);
        model_shift();
        expect_q("R10 changed at 3rd edge", model[W-1]);
        wait_n(SETTLE);
        set_clk(1'b0);

        // R4: remaining bits in order, then zeros
        for (int i = 0; i < 8; i++) clk_pulse_shift("R4 shift order");
        expect_q("R4 reads zero after word", 1'b0);

        // R4 with a second pattern, checking every bit
        load_word(8'h5A);
        for (int i = 0; i < 9; i++) clk_pulse_shift("R4 pattern 5A");

        // R5: serial ones fill from first stage
        load_word(8'h00);
        @(negedge sys_clk); ser_i = 1'b1;
        for (int i = 0; i < 8; i++) clk_pulse_shift("R5 serial entry");
        expect_q("R5 ones reached last stage", 1'b1);
        @(negedge sys_clk); ser_i = 1'b0;

        // R7: inhibit rising with clock low is a shift
        load_word(8'h81);
        set_inh(1'b1);
        model_shift();
        expect_q("R7 inhibit acts as clock", model[W-1]);
        set_inh(1'b0);

        // R6: clock pulses under high inhibit
        load_word(8'hC3);
        set_clk(1'b1);
        model_shift();
        expect_q("R6 legit edge before inhibit", model[W-1]);
        set_inh(1'b1);
        set_clk(1'b0);
        set_clk(1'b1);
        set_clk(1'b0);
        set_clk(1'b1);
        expect_q("R6 inhibit blocks clock", model[W-1]);
        set_clk(1'b0);
        set_inh(1'b0);
        expect_q("R8 inhibit fall no shift", model[W-1]);
        clk_pulse_shift("R6 shifting resumes");

        // R11: release load while combined level high
        @(negedge sys_clk);
        par_i  = 8'h7F;
        ld_n_i = 1'b0;
        wait_n(SETTLE);
        model = 8'h7F;
        ext_clk_i = 1'b1;
        wait_n(SETTLE);
        ld_n_i = 1'b1;
        wait_n(SETTLE);
        expect_q("R11 no shift on release", model[W-1]);
        set_clk(1'b0);
        expect_q("R11 fall no shift", model[W-1]);
        clk_pulse_shift("R11 next edge shifts");

        // R1 again: reset mid-stream
        load_word(8'hFF);
        @(negedge sys_clk);
        sys_rst = 1'b1;
        wait_n(2);
        expect_q("R1 reset mid-stream", 1'b0);
        @(negedge sys_clk);
        sys_rst = 1'b0;
        wait_n(SETTLE);
        expect_q("R9 complement after reset", 1'b0);

        wait_n(2);
        drain();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule